// File: doc/BRIEF.md
# Instruction Cycle Phase Sequencer

This block tracks the phase a simple processor's instruction cycle is in. It holds a 2-bit cycle code and moves through four phases: fetch, indirect, execute and interrupt. For each phase it raises one enable line towards the datapath. It then waits for the datapath to pulse a completion strobe before it picks the next phase.

The choice of next phase depends on the current phase. Fetch goes either to indirect or to execute, based on whether the fetched instruction uses indirect addressing. Indirect always goes to execute. Execute goes to interrupt only when an interrupt is both pending and enabled; otherwise it returns to fetch. Interrupt always returns to fetch. On entry to the interrupt phase, a one-cycle acknowledge tells the interrupt source that its request has been taken.

Top module: `inst_phase_seq`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the cycle code to 2'b00 (fetch), makes phase_en equal 4'b0001 and drives irq_ack low.
- R2: A rising edge with phase_done low leaves the cycle code unchanged, whatever the other inputs are.
- R3: At a rising edge in fetch (00) with phase_done high, the code becomes 01 (indirect) if ind_addr is high, and 10 (execute) otherwise.
- R4: At a rising edge in indirect (01) with phase_done high, the code becomes 10 (execute), regardless of ind_addr, irq_pend and irq_en.
- R5: At a rising edge in execute (10) with phase_done high, the code becomes 11 (interrupt) when irq_pend and irq_en are both high, and 00 (fetch) otherwise.
- R6: At a rising edge in interrupt (11) with phase_done high, the code becomes 00 (fetch).
- R7: In every cycle after reset, exactly one bit of phase_en is high, and it is bit number cycle_code (bit 0 fetch, bit 1 indirect, bit 2 execute, bit 3 interrupt).
- R8: irq_ack is high for exactly one cycle: the first cycle in which the code is 11 after a transition into interrupt. It is low in all other cycles.
- R9: irq_pend and irq_en have no effect unless the sequencer is leaving execute, and ind_addr has no effect unless it is leaving fetch.
- R10: When rst and phase_done are high at the same edge, reset wins: the code becomes 00 and irq_ack stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_done | input | 1 | Completion strobe for the current phase |
| ind_addr | input | 1 | Fetched instruction uses indirect addressing |
| irq_pend | input | 1 | An interrupt request is pending |
| irq_en | input | 1 | Interrupts are enabled |
| phase_en | output | 4 | One-hot phase enable, bit index equals cycle code |
| cycle_code | output | 2 | Current cycle code |
| irq_ack | output | 1 | One-cycle pulse on entry to interrupt |

## Verification
Two events can fall on the same edge: the completion strobe at the end of execute with an interrupt pending and enabled, and a synchronous reset. The bench drives the sequencer into execute, then raises rst, phase_done, irq_pend and irq_en together. It expects fetch with irq_ack low one edge later. A second case is where the acknowledge pulse overlaps a phase that lasts several cycles. The bench enters interrupt and holds phase_done low for several cycles, and it expects the acknowledge only in the first of those cycles.

// File: rtl/iphase_pkg.sv
package iphase_pkg;

  localparam int CODE_W    = 2;
  localparam int PHASE_CNT = 1 << CODE_W;

  typedef enum logic [CODE_W-1:0] {
    PH_FETCH = 2'b00,
    PH_INDIR = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INTR  = 2'b11
  } phase_t;

  // Successor of a phase at its end; inputs only matter in the phase they belong to.
  function automatic phase_t next_phase(phase_t cur, logic ind, logic pend, logic en);
    phase_t n;
    case (cur)
      PH_FETCH: n = ind ? PH_INDIR : PH_EXEC;
      PH_INDIR: n = PH_EXEC;
      PH_EXEC:  n = (pend && en) ? PH_INTR : PH_FETCH;
      default:  n = PH_FETCH;
    endcase
    return n;
  endfunction

  function automatic logic takes_interrupt(phase_t cur, logic pend, logic en);
    return (cur == PH_EXEC) && pend && en;
  endfunction

endpackage

// File: rtl/iphase_next.sv
module iphase_next
  import iphase_pkg::*;
(
  input  phase_t cur,
  input  logic   ind_addr,
  input  logic   irq_pend,
  input  logic   irq_en,
  output phase_t nxt,
  output logic   to_intr
);
  always_comb begin
    nxt     = next_phase(cur, ind_addr, irq_pend, irq_en);
    to_intr = takes_interrupt(cur, irq_pend, irq_en);
  end
endmodule

// File: rtl/iphase_state.sv
module iphase_state
  import iphase_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   advance,
  input  phase_t nxt,
  input  logic   to_intr,
  output phase_t code_q,
  output logic   ack_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= PH_FETCH;
      ack_q  <= 1'b0;
    end else begin
      if (advance) code_q <= nxt;
      ack_q <= advance && to_intr;
    end
  end

  // R1 / R10: reset dominates any strobe
  a_r1_reset_fetch: assert property (@(posedge clk)
    rst |=> (code_q == PH_FETCH) && !ack_q);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(code_q));

  a_r4_indir_to_exec: assert property (@(posedge clk) disable iff (rst)
    (advance && code_q == PH_INDIR) |=> (code_q == PH_EXEC));

  a_r6_intr_to_fetch: assert property (@(posedge clk) disable iff (rst)
    (advance && code_q == PH_INTR) |=> (code_q == PH_FETCH));

  a_r8_ack_on_entry: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> (code_q == PH_INTR) && ($past(code_q) == PH_EXEC));

  a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack_q |=> !ack_q);
endmodule

// File: rtl/iphase_decode.sv
module iphase_decode
  import iphase_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  phase_t               code_q,
  output logic [PHASE_CNT-1:0] phase_en
);
  for (genvar i = 0; i < PHASE_CNT; i++) begin : g_en
    assign phase_en[i] = (code_q == phase_t'(i));
  end

  a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_en) == 1);
endmodule

// File: rtl/inst_phase_seq.sv
module inst_phase_seq
  import iphase_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 phase_done,
  input  logic                 ind_addr,
  input  logic                 irq_pend,
  input  logic                 irq_en,
  output logic [PHASE_CNT-1:0] phase_en,
  output logic [CODE_W-1:0]    cycle_code,
  output logic                 irq_ack
);
  phase_t cur_q;
  phase_t nxt_w;
  logic   to_intr_w;

  iphase_next u_next (
    .cur(cur_q), .ind_addr(ind_addr), .irq_pend(irq_pend), .irq_en(irq_en),
    .nxt(nxt_w), .to_intr(to_intr_w)
  );

  iphase_state u_state (
    .clk(clk), .rst(rst), .advance(phase_done), .nxt(nxt_w),
    .to_intr(to_intr_w), .code_q(cur_q), .ack_q(irq_ack)
  );

  iphase_decode u_dec (
    .clk(clk), .rst(rst), .code_q(cur_q), .phase_en(phase_en)
  );

  assign cycle_code = cur_q;

  a_r3_fetch_branch: assert property (@(posedge clk) disable iff (rst)
    (phase_done && cycle_code == 2'b00) |=>
      (cycle_code == ($past(ind_addr) ? 2'b01 : 2'b10)));

  a_r5_exec_branch: assert property (@(posedge clk) disable iff (rst)
    (phase_done && cycle_code == 2'b10) |=>
      (cycle_code == (($past(irq_pend) && $past(irq_en)) ? 2'b11 : 2'b00)));

  // R9: the acknowledge only follows an execute end
  a_r9_ack_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_ack) |-> ($past(cycle_code) == 2'b10));
endmodule

// File: tb/inst_phase_seq_test.sv
module inst_phase_seq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       phase_done = 1'b0;
  logic       ind_addr = 1'b0;
  logic       irq_pend = 1'b0;
  logic       irq_en = 1'b0;
  logic [3:0] phase_en;
  logic [1:0] cycle_code;
  logic       irq_ack;

  int checks = 0;
  int errors = 0;

  inst_phase_seq uut (
    .clk(clk), .rst(rst), .phase_done(phase_done), .ind_addr(ind_addr),
    .irq_pend(irq_pend), .irq_en(irq_en), .phase_en(phase_en),
    .cycle_code(cycle_code), .irq_ack(irq_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [1:0] exp_code, input logic exp_ack);
    logic [3:0] exp_en;
    exp_en = 4'b0001 << exp_code;
    checks++;
    if (cycle_code !== exp_code) begin
      errors++;
      $display("FAIL %s code actual %b expected %b", tag, cycle_code, exp_code);
    end
    checks++;
    if (phase_en !== exp_en) begin
      errors++;
      $display("FAIL R7 (%s) phase_en actual %b expected %b", tag, phase_en, exp_en);
    end
    checks++;
    if (irq_ack !== exp_ack) begin
      errors++;
      $display("FAIL %s irq_ack actual %b expected %b", tag, irq_ack, exp_ack);
    end
  endtask

  // drive at negedge, one rising edge, sample at next negedge
  task automatic step(input logic d, input logic i, input logic p, input logic e);
    phase_done = d; ind_addr = i; irq_pend = p; irq_en = e;
    @(posedge clk);
    @(negedge clk);
    phase_done = 1'b0;
  endtask

  task automatic do_reset;
    rst = 1'b1;
    step(0, 0, 0, 0);
    rst = 1'b0;
    check("R1 reset", 2'b00, 1'b0);
  endtask

  task automatic t_hold;
    for (int k = 0; k < 4; k++) begin
      step(0, 1, 1, 1);
      check("R2 hold in fetch", 2'b00, 1'b0);
    end
  endtask

  task automatic t_direct;
    step(1, 0, 1, 1);
    check("R3 fetch direct to exec (R9 irq ignored)", 2'b10, 1'b0);
    step(0, 0, 1, 1);
    check("R2 hold in exec", 2'b10, 1'b0);
    step(1, 1, 0, 1);
    check("R5 exec to fetch no pend (R9 ind ignored)", 2'b00, 1'b0);
  endtask

  task automatic t_indirect;
    step(1, 1, 0, 0);
    check("R3 fetch to indirect", 2'b01, 1'b0);
    step(0, 0, 1, 1);
    step(0, 0, 1, 1);
    check("R2 hold in indirect", 2'b01, 1'b0);
    step(1, 1, 1, 1);
    check("R4 indirect to exec", 2'b10, 1'b0);
    step(1, 0, 0, 0);
    check("R5 exec to fetch", 2'b00, 1'b0);
  endtask

  task automatic t_irq;
    step(1, 0, 0, 0);
    check("R3 to exec", 2'b10, 1'b0);
    step(1, 0, 1, 1);
    check("R5/R8 exec to intr with ack", 2'b11, 1'b1);
    step(0, 0, 1, 1);
    check("R8 ack single cycle", 2'b11, 1'b0);
    step(0, 1, 1, 1);
    check("R2 hold in intr", 2'b11, 1'b0);
    step(1, 1, 1, 1);
    check("R6 intr to fetch", 2'b00, 1'b0);
  endtask

  task automatic t_masked;
    step(1, 0, 0, 0);
    step(1, 0, 1, 0);
    check("R5 pend masked to fetch", 2'b00, 1'b0);
    step(1, 0, 0, 0);
    step(1, 0, 0, 1);
    check("R5 enable without pend to fetch", 2'b00, 1'b0);
  endtask

  task automatic t_reset_vs_done;
    step(1, 0, 0, 0);
    check("R3 to exec before reset", 2'b10, 1'b0);
    rst = 1'b1;
    step(1, 0, 1, 1);
    rst = 1'b0;
    check("R10 reset beats strobe", 2'b00, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_hold();
    t_direct();
    t_indirect();
    t_irq();
    t_masked();
    t_reset_vs_done();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule